// File: doc/BRIEF.md
# Configurable GPIO Interrupt Detector

This block turns already-synchronized GPIO inputs into interrupt requests. Inputs are grouped into banks of 32 pins. Each pin has its own trigger mode, built from three per-bank configuration words:

- **Kind** selects level or edge detection.
- **Polarity** selects high/rising or low/falling.
- **Both-edges** fires on any transition.

A detection sets a sticky status bit. Software clears that bit by writing 1 to it.

A per-bank mask decides which status bits reach the single combined interrupt line. The mask cannot be written directly. Software changes it only through two strobe words:

- One word clears mask bits (enables pins).
- The other word sets mask bits (disables pins).

All registers sit on a simple word-addressed write bus with a combinational read port. The bank number is `bus_addr[7:5]`, the register index is `bus_addr[4:2]`, and `bus_addr[1:0]` must be zero for an access to take effect. The pin synchronizers live in the surrounding GPIO core, not in this block.

Top module: `gpio_irq_detect`

## Requirements
- R1: While reset is held and right after it, every mask bit reads 1, every status bit and every kind, polarity and both-edges bit reads 0, and `irq_out` is 0.
- R2: A write to register index 1 (unmask) clears each mask bit whose data bit is 1. Data bits of 0 leave the mask unchanged. Index 0 reads the mask, where 1 means masked.
- R3: A write to register index 2 (mask-set) sets each mask bit whose data bit is 1. Writing all ones masks every pin of the bank and drops a pending interrupt.
- R4: Register index 3 reads the status word. Writing 1 to a status bit clears it on that clock edge, unless a new detection occurs on the same edge.
- R5: With kind bit 0 (index 4), a pin sets its status bit on every edge at which it sits at its active level. The active level is high when its polarity bit (index 5) is 1 and low when it is 0.
- R6: With kind bit 1 and both-edges bit 0, the status bit sets when the pin differs from its value one cycle earlier in the selected direction. Polarity 1 selects rising (0 to 1) and polarity 0 selects falling (1 to 0).
- R7: With kind bit 1 and both-edges bit (index 6) set to 1, either transition sets the status bit, whatever the polarity bit holds.
- R8: Status bits are recorded whether or not the pin is masked. `irq_out` rises on the edge after any bank has a status bit set with its mask bit clear, and falls on the edge after none has.
- R9: When a write-1 clear and a detection hit the same status bit on the same edge, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_sync | input | NUM_BANKS*32 | Synchronized pin levels; bank b occupies bits [32b+31:32b] |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address: bank in [7:5], register index in [4:2], [1:0] must be 0 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read of the addressed register; 0 for write-only or unused words |
| irq_out | output | 1 | Registered OR of all unmasked status bits |

## Verification
The hardest case to reach from the ports is a write-1 clear landing on the same edge as a fresh detection. The bench reaches it with a level-sensitive pin held at its active level while the clear is issued, and then shows that the bit survives. Each edge mode also depends on the pin's value one cycle earlier. For that reason every table vector holds the pin at its start value for two cycles, clears the status, and only then moves the pin. The clear edge therefore sees a steady previous value, and the read that follows isolates the single transition under test.

// File: rtl/gid_pkg.sv
package gid_pkg;

  typedef enum logic [2:0] {
    REG_MASK    = 3'd0,
    REG_UNMASK  = 3'd1,
    REG_MASKSET = 3'd2,
    REG_STATUS  = 3'd3,
    REG_KIND    = 3'd4,
    REG_POL     = 3'd5,
    REG_BOTH    = 3'd6,
    REG_NONE    = 3'd7
  } gid_reg_e;

  // One pin's trigger decision from its configuration and two samples.
  function automatic logic pin_hit(input logic kind, input logic pol,
                                   input logic both, input logic prev,
                                   input logic cur);
    if (!kind) return pol ? cur : !cur;
    if (both) return prev ^ cur;
    return pol ? (cur & !prev) : (!cur & prev);
  endfunction

endpackage

// File: rtl/gid_trigger.sv
module gid_trigger #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] prev,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] both,
  output logic [W-1:0] hit
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign hit[i] = gid_pkg::pin_hit(kind[i], pol[i], both[i], prev[i], cur[i]);
  end
endmodule

// File: rtl/gid_bank.sv
module gid_bank
  import gid_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pins,
  input  logic         wr_en,
  input  gid_reg_e     reg_idx,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pending
);
  logic [W-1:0] mask_q, status_q, kind_q, pol_q, both_q, prev_q;
  logic [W-1:0] hit, clr_bits;
  logic we_unmask, we_maskset, we_status;

  assign we_unmask  = wr_en && (reg_idx == REG_UNMASK);
  assign we_maskset = wr_en && (reg_idx == REG_MASKSET);
  assign we_status  = wr_en && (reg_idx == REG_STATUS);
  assign clr_bits   = we_status ? wdata : '0;

  gid_trigger #(.W(W)) trig_i (
    .cur  (pins),
    .prev (prev_q),
    .kind (kind_q),
    .pol  (pol_q),
    .both (both_q),
    .hit  (hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q   <= '1;
      status_q <= '0;
      kind_q   <= '0;
      pol_q    <= '0;
      both_q   <= '0;
      prev_q   <= '0;
    end else begin
      prev_q   <= pins;
      status_q <= (status_q & ~clr_bits) | hit;
      if (we_unmask)  mask_q <= mask_q & ~wdata;
      if (we_maskset) mask_q <= mask_q | wdata;
      if (wr_en && reg_idx == REG_KIND) kind_q <= wdata;
      if (wr_en && reg_idx == REG_POL)  pol_q  <= wdata;
      if (wr_en && reg_idx == REG_BOTH) both_q <= wdata;
    end
  end

  always_comb begin
    case (reg_idx)
      REG_MASK:   rdata = mask_q;
      REG_STATUS: rdata = status_q;
      REG_KIND:   rdata = kind_q;
      REG_POL:    rdata = pol_q;
      REG_BOTH:   rdata = both_q;
      default:    rdata = '0;
    endcase
  end

  assign pending = status_q & ~mask_q;

  // R2: unmasked bits are clear after an unmask write
  p_unmask_r2: assert property (@(posedge clk) disable iff (!rst_n)
    we_unmask |=> ((mask_q & $past(wdata)) == '0));
  // R3: mask-set bits are set after the write
  p_maskset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    we_maskset |=> ((mask_q & $past(wdata)) == $past(wdata)));
  // R4: cleared bits without a new hit read 0
  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    we_status |=> ((status_q & $past(wdata & ~hit)) == '0));
  // R9: a detection always leaves its status bit set
  p_hit_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((status_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gid_pkg::*;
#(
  parameter int NUM_BANKS     = 2,
  parameter int PINS_PER_BANK = 32,
  parameter int ADDR_W        = 8
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_BANKS*PINS_PER_BANK-1:0] pins_sync,
  input  logic                               bus_wr,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic [PINS_PER_BANK-1:0]           bus_wdata,
  output logic [PINS_PER_BANK-1:0]           bus_rdata,
  output logic                               irq_out
);
  localparam int W          = PINS_PER_BANK;
  localparam int BANK_LSB   = 5;
  localparam int BANK_SEL_W = ADDR_W - BANK_LSB;

  logic [BANK_SEL_W-1:0]     bank_sel;
  gid_reg_e                  reg_idx;
  logic                      word_ok;
  logic [W-1:0]              bank_rd [NUM_BANKS];
  logic [NUM_BANKS*W-1:0]    pending_all;
  logic                      any_pending;
  logic                      irq_q;

  assign bank_sel = bus_addr[ADDR_W-1:BANK_LSB];
  assign reg_idx  = gid_reg_e'(bus_addr[4:2]);
  assign word_ok  = (bus_addr[1:0] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic sel;
    assign sel = word_ok && (bank_sel == BANK_SEL_W'(b));
    gid_bank #(.W(W)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .pins    (pins_sync[b*W +: W]),
      .wr_en   (bus_wr && sel),
      .reg_idx (reg_idx),
      .wdata   (bus_wdata),
      .rdata   (bank_rd[b]),
      .pending (pending_all[b*W +: W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (word_ok && bank_sel == BANK_SEL_W'(b)) bus_rdata = bank_rd[b];
    end
  end

  assign any_pending = |pending_all;

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= any_pending;
  end

  assign irq_out = irq_q;

  // R8: interrupt follows pending state one edge later
  p_irq_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
    any_pending |=> irq_out);
  p_irq_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !any_pending |=> !irq_out);
endmodule

// File: tb/gpio_irq_detect_tb_top.sv
module gpio_irq_detect_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] pins_sync = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  gpio_irq_detect dut_i (
    .clk(clk), .rst_n(rst_n), .pins_sync(pins_sync), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out)
  );

  // {kind, pol, both, start, end, expected status}
  localparam logic [5:0] VEC [12] = '{
    6'b010_01_1, // R5 level high reached
    6'b010_00_0, // R5 level high absent
    6'b000_10_1, // R5 level low reached
    6'b000_11_0, // R5 level low absent
    6'b110_01_1, // R6 rising
    6'b110_10_0, // R6 rising mode, falling pin
    6'b100_10_1, // R6 falling
    6'b100_01_0, // R6 falling mode, rising pin
    6'b101_01_1, // R7 both, pol 0, rising
    6'b111_10_1, // R7 both, pol 1, falling
    6'b111_11_0, // R7 both, steady
    6'b010_10_1  // R9 level active at clear, sticky after
  };

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    // R1 reset state
    bus_addr = 8'h00; #1 chk("R1 mask", bus_rdata, 32'hFFFF_FFFF);
    bus_addr = 8'h0C; #1 chk("R1 status", bus_rdata, 32'h0);
    bus_addr = 8'h30; #1 chk("R1 kind", bus_rdata, 32'h0);
    chk("R1 irq", {31'b0, irq_out}, 32'h0);
    @(negedge clk) rst_n = 1'b1;

    // Table of vectors on bank 0 pin 5 (all masked)
    for (int i = 0; i < 12; i++) begin
      wr(8'h10, {26'b0, VEC[i][5], 5'b0});
      wr(8'h14, {26'b0, VEC[i][4], 5'b0});
      wr(8'h18, {26'b0, VEC[i][3], 5'b0});
      pins_sync[5] = VEC[i][2];
      repeat (2) @(negedge clk);
      wr(8'h0C, 32'h20);
      pins_sync[5] = VEC[i][1];
      rd(8'h0C, v);
      chk($sformatf("R5/R6/R7/R9 vector %0d", i), {31'b0, v[5]}, {31'b0, VEC[i][0]});
      chk("R8 masked no irq", {31'b0, irq_out}, 32'h0);
    end

    // R9 directed: level-high pin 6 held active across a clear
    wr(8'h14, 32'h40);
    pins_sync[6] = 1'b1;
    repeat (2) @(negedge clk);
    wr(8'h0C, 32'h40);
    rd(8'h0C, v);
    chk("R9 detect beats clear", {31'b0, v[6]}, 32'h1);
    pins_sync[6] = 1'b0;
    @(negedge clk);
    wr(8'h0C, 32'h40);
    rd(8'h0C, v);
    chk("R4 clear sticks", {31'b0, v[6]}, 32'h0);

    // Bank 1 pin 3: rising edge, unmasked
    wr(8'h30, 32'h8);
    wr(8'h34, 32'h8);
    wr(8'h2C, 32'h8);
    wr(8'h24, 32'h8);
    rd(8'h20, v);
    chk("R2 unmask", v, 32'hFFFF_FFF7);
    wr(8'h24, 32'h0);
    rd(8'h20, v);
    chk("R2 zero ignored", v, 32'hFFFF_FFF7);
    chk("R8 idle irq", {31'b0, irq_out}, 32'h0);
    bus_addr = 8'h2C;
    pins_sync[35] = 1'b1;
    @(negedge clk); #1;
    chk("R6 status set", {31'b0, bus_rdata[3]}, 32'h1);
    chk("R8 irq lag", {31'b0, irq_out}, 32'h0);
    @(negedge clk); #1;
    chk("R8 irq raised", {31'b0, irq_out}, 32'h1);
    wr(8'h2C, 32'h8);
    @(negedge clk); #1;
    chk("R4 irq dropped after clear", {31'b0, irq_out}, 32'h0);
    rd(8'h2C, v);
    chk("R8 masked pin 4 recorded", v & 32'h18, 32'h10);

    // R3: unmask pending pin 4, then mask everything
    wr(8'h24, 32'h10);
    @(negedge clk); #1;
    chk("R8 unmasked pending irq", {31'b0, irq_out}, 32'h1);
    wr(8'h28, 32'hFFFF_FFFF);
    @(negedge clk); #1;
    chk("R3 mask all drops irq", {31'b0, irq_out}, 32'h0);
    rd(8'h20, v);
    chk("R3 mask all", v, 32'hFFFF_FFFF);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule